// File: doc/BRIEF.md
# SMRAM Address Decode and Guard

This block sits in a system memory controller and steers every memory cycle either to the system-management RAM or to normal main memory. For each cycle it captures the address, whether the CPU or an alternate master (DMA and the like) owns the bus, and the CPU's active-low SMM-active strobe. From these and a small control register it raises exactly one chip-select, SMRAM or main. When a cycle from an alternate master would have landed in SMRAM, it raises an access-denied flag instead.

The window sits on 32 KB boundaries. After reset it covers 38000h to 3FFFFh and overlays main memory there. Software can move it anywhere on a 32 KB boundary. A relocation bit doubles it to 64 KB, so that it spans a full handler segment from its base. Three control bits cover the other uses. An open bit lets boot code reach SMRAM before the first SMI arrives. A force bit lets the SMI handler reach the main memory that lies under the window. The address, owner and SMM strobe are captured in one register stage. The decode outputs are combinational from that stage.

Top module: `smram_guard`

## Requirements
- R1: After reset all three outputs are low, the window base is 38000h, the window is 32 KB (38000h–3FFFFh), and the open, force and relocation bits are 0.
- R2: Outputs describe the cycle presented (cyc_valid high) at the previous rising clock edge. If no cycle was presented at that edge, all three outputs are low.
- R3: For every presented cycle exactly one of sel_smram and sel_main is high.
- R4: A CPU cycle inside the window selects SMRAM when smm_act_n was low with it. With smm_act_n high and the open bit clear, it selects main memory. A cycle outside the window always selects main memory.
- R5: With the open bit set, a CPU cycle inside the window selects SMRAM even when smm_act_n is high.
- R6: An alternate-master cycle (cyc_cpu low) never selects SMRAM. If it hits the window while SMRAM would be selected for the CPU, deny is high for that one output cycle and sel_main is high.
- R7: An alternate-master cycle that hits the window while SMRAM is not selectable, or that falls outside the window, selects main memory and leaves deny low.
- R8: With the force bit set, cycles inside the window select main memory, even in SMM and even with the open bit set, and deny stays low.
- R9: The window starts at cfg_base × 32 KB (cfg_base is address bits [AW-1:15]). It is 32 KB long with the relocation bit clear and 64 KB long with it set. The base and the last byte lie inside the window. The byte below the base and the byte just past the end lie outside it.
- R10: A control write (cfg_we high at a rising edge) governs every cycle presented at that edge or at any later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_base | input | AW-15 | New window base, in 32 KB units |
| cfg_open | input | 1 | New open bit: CPU reaches SMRAM outside SMM |
| cfg_force | input | 1 | New force bit: window cycles go to main memory |
| cfg_reloc | input | 1 | New relocation bit: window grows to 64 KB |
| cyc_valid | input | 1 | A memory cycle's address phase is present |
| cyc_addr | input | AW | Cycle byte address |
| cyc_cpu | input | 1 | High when the CPU owns the cycle, low for alternate masters |
| smm_act_n | input | 1 | Active-low SMM-active strobe from the CPU |
| sel_smram | output | 1 | Chip-select for SMRAM |
| sel_main | output | 1 | Chip-select for main memory |
| deny | output | 1 | Alternate master blocked from SMRAM |

## Verification
The hardest case to reach is a DMA cycle that hits the window while SMRAM is selectable. The denial depends on both the master and the routing state, so the bench has to put SMRAM in a selectable state first. It does this in two ways: once with the SMM strobe low, and once with the strobe high and the open bit set. In each state it issues the same address as a CPU cycle and as a DMA cycle, back to back. The window edges are reached by writing a relocated base and probing one byte on each side of both edges, in both window sizes.

// File: rtl/smram_guard.sv
module smram_guard #(
  parameter int AW = 32,
  parameter int WIN_LOG2 = 15,
  parameter logic [AW-1:0] BASE_RST = 32'h0003_8000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-WIN_LOG2-1:0] cfg_base,
  input  logic                cfg_open,
  input  logic                cfg_force,
  input  logic                cfg_reloc,
  input  logic                cyc_valid,
  input  logic [AW-1:0]       cyc_addr,
  input  logic                cyc_cpu,
  input  logic                smm_act_n,
  output logic                sel_smram,
  output logic                sel_main,
  output logic                deny
);
  localparam int BW = AW - WIN_LOG2;
  localparam logic [AW:0] SZ_SMALL = (AW+1)'(1) << WIN_LOG2;
  localparam logic [AW:0] SZ_BIG   = (AW+1)'(1) << (WIN_LOG2 + 1);

  logic [BW-1:0] base_q;
  logic          open_q, force_q, reloc_q;
  logic          q_valid, q_cpu, q_smm_n;
  logic [AW-1:0] q_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      base_q  <= BASE_RST[AW-1:WIN_LOG2];
      open_q  <= 1'b0;
      force_q <= 1'b0;
      reloc_q <= 1'b0;
    end else if (cfg_we) begin
      base_q  <= cfg_base;
      open_q  <= cfg_open;
      force_q <= cfg_force;
      reloc_q <= cfg_reloc;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_cpu   <= 1'b0;
      q_smm_n <= 1'b1;
    end else begin
      q_valid <= cyc_valid;
      if (cyc_valid) begin
        q_addr  <= cyc_addr;
        q_cpu   <= cyc_cpu;
        q_smm_n <= smm_act_n;
      end
    end

  logic [AW:0] win_lo, win_hi, addr_x;
  logic        hit, route;

  assign win_lo = {1'b0, base_q, {WIN_LOG2{1'b0}}};
  assign win_hi = win_lo + (reloc_q ? SZ_BIG : SZ_SMALL);
  assign addr_x = {1'b0, q_addr};
  assign hit    = (addr_x >= win_lo) && (addr_x < win_hi);
  assign route  = (~q_smm_n | open_q) & ~force_q;

  assign sel_smram = q_valid & hit & route & q_cpu;
  assign sel_main  = q_valid & ~(hit & route & q_cpu);
  assign deny      = q_valid & hit & route & ~q_cpu;

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_valid) |-> !(sel_smram | sel_main | deny));

  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_valid) |-> $countones({sel_smram, sel_main}) == 1);

  a_r6_dma_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_valid & ~cyc_from_dma_n()) |-> !sel_smram);

  a_r6_deny_to_main: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> sel_main && !sel_smram);

  a_r7_cpu_never_denied: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_valid & cyc_cpu) |-> !deny);

  function automatic logic cyc_from_dma_n();
    return cyc_cpu;
  endfunction
endmodule

// File: tb/test_smram_guard.sv
`timescale 1ns/1ps
module test_smram_guard;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_open = 1'b0, cfg_force = 1'b0, cfg_reloc = 1'b0;
  logic [AW-16:0] cfg_base = '0;
  logic cyc_valid = 1'b0, cyc_cpu = 1'b0, smm_act_n = 1'b1;
  logic [AW-1:0] cyc_addr = '0;
  logic sel_smram, sel_main, deny;

  int checks = 0, fails = 0;
  logic [AW-16:0] m_base = 17'h7;
  logic m_open = 0, m_force = 0, m_reloc = 0;

  always #2.5 clk = ~clk;

  smram_guard i_smram_guard (.*);

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {smram,main,deny} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] model(logic [AW-1:0] a, logic cpu, logic sn);
    longint lo = longint'(m_base) << 15;
    longint hi = lo + (m_reloc ? 65536 : 32768);
    logic h = (longint'(a) >= lo) && (longint'(a) < hi);
    logic r = (!sn || m_open) && !m_force;
    return {h && r && cpu, !(h && r && cpu), h && r && !cpu};
  endfunction

  task automatic write_cfg(logic [AW-16:0] b, logic o, logic f, logic r);
    @(negedge clk);
    cfg_we = 1; cfg_base = b; cfg_open = o; cfg_force = f; cfg_reloc = r;
    @(posedge clk); #1;
    cfg_we = 0;
    m_base = b; m_open = o; m_force = f; m_reloc = r;
  endtask

  task automatic run_cycle(string req, logic [AW-1:0] a, logic cpu, logic sn);
    @(negedge clk);
    cyc_valid = 1; cyc_addr = a; cyc_cpu = cpu; smm_act_n = sn;
    @(posedge clk); #1;
    check(req, {sel_smram, sel_main, deny}, model(a, cpu, sn));
    cyc_valid = 0; smm_act_n = 1;
  endtask

  task automatic t_reset;
    check("R1 reset", {sel_smram, sel_main, deny}, 3'b000);
    run_cycle("R1 base", 32'h38000, 1, 0);
    run_cycle("R1 top", 32'h3FFFF, 1, 0);
    run_cycle("R1 below", 32'h37FFF, 1, 0);
    run_cycle("R1 above", 32'h40000, 1, 0);
  endtask

  task automatic t_idle;
    run_cycle("R2 cycle", 32'h39000, 1, 0);
    @(posedge clk); #1;
    check("R2 idle", {sel_smram, sel_main, deny}, 3'b000);
  endtask

  task automatic t_smm;
    run_cycle("R4 smm in", 32'h3A000, 1, 0);
    run_cycle("R4 no smm", 32'h3A000, 1, 1);
    run_cycle("R4 outside", 32'h1000, 1, 0);
    check("R3 model sanity", model(32'h3A000, 1, 0), 3'b100);
  endtask

  task automatic t_open;
    write_cfg(17'h7, 1, 0, 0);
    run_cycle("R5 open cpu", 32'h38010, 1, 1);
    run_cycle("R6 open dma", 32'h38010, 0, 1);
    write_cfg(17'h7, 0, 0, 0);
  endtask

  task automatic t_dma;
    run_cycle("R6 smm cpu", 32'h3C000, 1, 0);
    run_cycle("R6 smm dma", 32'h3C000, 0, 0);
    check("R6 deny expected", model(32'h3C000, 0, 0), 3'b011);
    run_cycle("R7 dma no smm", 32'h3C000, 0, 1);
    run_cycle("R7 dma outside", 32'h50000, 0, 0);
  endtask

  task automatic t_force;
    write_cfg(17'h7, 1, 1, 0);
    run_cycle("R8 force cpu", 32'h3E000, 1, 0);
    run_cycle("R8 force dma", 32'h3E000, 0, 0);
    write_cfg(17'h7, 0, 0, 0);
  endtask

  task automatic t_reloc;
    write_cfg(17'h20, 0, 0, 1);
    run_cycle("R9 base", 32'h100000, 1, 0);
    run_cycle("R9 last", 32'h10FFFF, 1, 0);
    run_cycle("R9 below", 32'h0FFFFF, 1, 0);
    run_cycle("R9 past", 32'h110000, 1, 0);
    run_cycle("R9 old win", 32'h38000, 1, 0);
    write_cfg(17'h20, 0, 0, 0);
    run_cycle("R9 small last", 32'h107FFF, 1, 0);
    run_cycle("R9 small past", 32'h108000, 1, 0);
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    cfg_we = 1; cfg_base = 17'h7; cfg_open = 0; cfg_force = 0; cfg_reloc = 0;
    cyc_valid = 1; cyc_addr = 32'h38000; cyc_cpu = 1; smm_act_n = 0;
    @(posedge clk); #1;
    cfg_we = 0; cyc_valid = 0; smm_act_n = 1;
    m_base = 17'h7; m_open = 0; m_force = 0; m_reloc = 0;
    check("R10 same edge", {sel_smram, sel_main, deny}, 3'b100);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_idle();
    t_smm();
    t_open();
    t_dma();
    t_force();
    t_reloc();
    t_same_edge();
    repeat (2) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule